// File: doc/BRIEF.md
# USB Device Clock Divider and Gate

This block derives the USB device clock from the output of a PLL. It runs on the PLL clock itself and divides it by 1, 2 or 4 according to a two-bit ratio select, so that a 48, 96 or 192 MHz PLL output yields 48 MHz. There is no other clock source. A single enable flag decides whether the divided clock reaches the output. Software sets the flag with one write strobe and clears it with another, and reads it back on a status output.

The divided clock leaves the block only when the enable flag is set and the PLL reports lock. Ratio changes, enable changes and lock changes are all applied at a period boundary of the divider. Every output period is therefore complete and has the correct width, and no glitch reaches the USB logic. All state resets to off.

Top module: `usb_clk_gen`

## Requirements
- R1: While reset is asserted and on release, `en_status_o` is 0, `usb_clk_o` is low and the divider counter is cleared.
- R2: A pulse on `en_set_i` sets `en_status_o` at the next clock edge. With no strobe, the flag holds its value.
- R3: A pulse on `en_clr_i` clears `en_status_o` at the next clock edge. When both strobes are active in the same cycle, the clear wins.
- R4: The ratio select encodes 2'b00 as /1, 2'b01 as /2, 2'b10 as /4 and 2'b11 as /1. For /2 and /4, the output is high for the first half of each N-cycle period, starting at the edge where the counter wraps. For /1, the output follows the high phase of the PLL clock.
- R5: A new ratio select value takes effect only at the edge where the counter wraps. A change in the middle of a period does not shorten or stretch that period.
- R6: At each period boundary, the gate samples (enable flag AND `pll_lock_i`). If that value was 0, the output stays low for the whole period.
- R7: If lock drops while the flag is set, the output is low from the next period boundary onward and `en_status_o` stays 1. When lock returns, the output resumes at a later boundary without a new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PLL output clock, the source of the USB clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pll_lock_i | input | 1 | PLL lock indication, synchronous to clk_i |
| div_sel_i | input | 2 | Ratio select (/1, /2, /4, /1) |
| en_set_i | input | 1 | Write-one strobe that turns the USB clock on |
| en_clr_i | input | 1 | Write-one strobe that turns the USB clock off |
| en_status_o | output | 1 | Readback of the enable flag |
| usb_clk_o | output | 1 | Gated, divided USB device clock |

## Verification
A corrupted divider counter or latched ratio shows on `usb_clk_o` as a period of the wrong length, or a high phase in the wrong cycle, within at most four PLL cycles. The bench samples the output in both clock phases of every cycle, so either error is caught. A gate that misses its boundary sampling shows as a high phase after lock or enable drops, or as a missing phase after they return, within one period. A wrong enable flag shows on `en_status_o` one edge after the strobe.

// File: rtl/usbclk_pkg.sv
package usbclk_pkg;
    localparam int SEL_W     = 2;
    localparam int MAX_RATIO = 4;
    localparam int CNT_W     = $clog2(MAX_RATIO);
    localparam int RAT_W     = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
        logic             run;
        logic             out;
    } div_state_t;

    function automatic logic [RAT_W-1:0] sel_ratio(input logic [SEL_W-1:0] s);
        case (s)
            2'b01:   sel_ratio = RAT_W'(2);
            2'b10:   sel_ratio = RAT_W'(4);
            default: sel_ratio = RAT_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/usbclk_enable.sv
module usbclk_enable (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic en_o
);
    logic en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (set_i) en_d = 1'b1;
        if (clr_i) en_d = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b0;
        else         en_q <= en_d;
    end

    assign en_o = en_q;
endmodule

// File: rtl/usbclk_divider.sv
module usbclk_divider
    import usbclk_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             lock_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             out_o,
    output logic             run_o,
    output logic [SEL_W-1:0] sel_o,
    output logic [CNT_W-1:0] cnt_o
);
    div_state_t s_d, s_q;
    logic [RAT_W-1:0] n_cur, n_new;
    logic             wrap;

    always_comb begin
        s_d   = s_q;
        n_cur = sel_ratio(s_q.sel);
        wrap  = ({1'b0, s_q.cnt} == n_cur - RAT_W'(1));
        n_new = n_cur;
        if (wrap) begin
            s_d.cnt = '0;
            s_d.sel = sel_i;
            s_d.run = en_i & lock_i;
            n_new   = sel_ratio(sel_i);
            s_d.out = s_d.run & (n_new > RAT_W'(1));
        end else begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
            s_d.out = s_q.run & ({1'b0, s_d.cnt} < (n_cur >> 1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign out_o = s_q.out;
    assign run_o = s_q.run;
    assign sel_o = s_q.sel;
    assign cnt_o = s_q.cnt;
endmodule

// File: rtl/usb_clk_gen.sv
module usb_clk_gen
    import usbclk_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pll_lock_i,
    input  logic [SEL_W-1:0] div_sel_i,
    input  logic             en_set_i,
    input  logic             en_clr_i,
    output logic             en_status_o,
    output logic             usb_clk_o
);
    logic             en_flag;
    logic             div_out;
    logic             div_run;
    logic [SEL_W-1:0] div_sel;
    logic [CNT_W-1:0] div_cnt;
    logic             pass_d, pass_q;

    usbclk_enable u_en (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (en_set_i),
        .clr_i (en_clr_i),
        .en_o  (en_flag)
    );

    usbclk_divider u_div (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en_flag),
        .lock_i(pll_lock_i),
        .sel_i (div_sel_i),
        .out_o (div_out),
        .run_o (div_run),
        .sel_o (div_sel),
        .cnt_o (div_cnt)
    );

    // Pass-through gate for /1, updated on the low phase so the high phase never gets cut
    always_comb pass_d = div_run & (sel_ratio(div_sel) == RAT_W'(1));

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pass_q <= 1'b0;
        else         pass_q <= pass_d;
    end

    assign en_status_o = en_flag;
    assign usb_clk_o   = div_out | (clk_i & pass_q);
endmodule

// File: rtl/usbclk_chk.sv
module usbclk_chk
    import usbclk_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             pll_lock_i,
    input logic             en_set_i,
    input logic             en_clr_i,
    input logic             en_status_o,
    input logic             div_out,
    input logic [SEL_W-1:0] div_sel,
    input logic [CNT_W-1:0] div_cnt
);
    AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_set_i && !en_clr_i |=> en_status_o); // R2
    AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_set_i && !en_clr_i |=> $stable(en_status_o)); // R2
    AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_clr_i |=> !en_status_o); // R3
    AST_SEL_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_cnt != '0 |-> $stable(div_sel)); // R5
    AST_RISE_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(div_out) |-> $past(pll_lock_i) && $past(en_status_o)); // R6
    AST_RISE_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(div_out) |-> div_cnt == '0); // R4
endmodule

bind usb_clk_gen usbclk_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pll_lock_i (pll_lock_i),
    .en_set_i   (en_set_i),
    .en_clr_i   (en_clr_i),
    .en_status_o(en_status_o),
    .div_out    (div_out),
    .div_sel    (div_sel),
    .div_cnt    (div_cnt)
);

// File: tb/usb_clk_gen_test.sv
`timescale 1ns/1ps
module usb_clk_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lock = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       set = 1'b0;
    logic       clr = 1'b0;
    logic       status;
    logic       uclk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench reference state
    int  m_cnt = 0;
    int  m_sel = 0;
    bit  m_run = 0;
    bit  m_out = 0;
    bit  m_en  = 0;
    bit  m_pass = 0;

    always #2 clk = ~clk;

    usb_clk_gen uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .pll_lock_i (lock),
        .div_sel_i  (sel),
        .en_set_i   (set),
        .en_clr_i   (clr),
        .en_status_o(status),
        .usb_clk_o  (uclk)
    );

    function automatic int ratio_of(input int s);
        if (s == 1) return 2;
        if (s == 2) return 4;
        return 1;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // one PLL cycle: reference update at edge, high-phase check, low-phase check
    task automatic cycle(input string tag);
        int n;
        @(posedge clk);
        n = ratio_of(m_sel);
        if (m_cnt == n - 1) begin
            m_cnt = 0;
            m_sel = int'(sel);
            m_run = m_en && lock;
            m_out = m_run && (ratio_of(m_sel) > 1);
        end else begin
            m_cnt++;
            m_out = m_run && (m_cnt < n / 2);
        end
        if (clr) m_en = 0;
        else if (set) m_en = 1;
        #1;
        check(uclk, m_out | m_pass, m_run ? tag : "R6");
        #2;
        m_pass = m_run && (ratio_of(m_sel) == 1);
        check(uclk, m_out, m_run ? tag : "R6");
        check(status, m_en, "R2");
    endtask

    task automatic drive(input bit s, input bit c, input bit l, input logic [1:0] d);
        set = s; clr = c; lock = l; sel = d;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(status, 1'b0, "R1");
        check(uclk, 1'b0, "R1");
        #2;
        check(uclk, 1'b0, "R1");
        #1;
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R6: enabled but no lock -> no output
        drive(1, 0, 0, 2'b01); cycle("R6");
        drive(0, 0, 0, 2'b01);
        repeat (6) cycle("R6");
        // lock arrives: /2 then /4
        drive(0, 0, 1, 2'b01);
        repeat (8) cycle("R4");
        drive(0, 0, 1, 2'b10);
        repeat (9) cycle("R5");
        drive(0, 0, 1, 2'b11);
        repeat (6) cycle("R4");
        drive(0, 0, 1, 2'b00);
        repeat (6) cycle("R4");
        // R7: lock drop keeps flag, output stops, then resumes
        drive(0, 0, 1, 2'b10);
        repeat (6) cycle("R4");
        drive(0, 0, 0, 2'b10);
        repeat (8) cycle("R7");
        check(status, 1'b1, "R7");
        drive(0, 0, 1, 2'b10);
        repeat (8) cycle("R7");
        // R3: both strobes -> clear wins
        drive(1, 1, 1, 2'b10); cycle("R3");
        check(status, 1'b0, "R3");
        drive(0, 0, 1, 2'b10);
        repeat (8) cycle("R6");
        // R5: mid-period select change
        drive(1, 0, 1, 2'b10); cycle("R2");
        drive(0, 0, 1, 2'b10);
        repeat (5) cycle("R5");
        drive(0, 0, 1, 2'b01); cycle("R5");
        drive(0, 0, 1, 2'b10);
        repeat (6) cycle("R5");

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit s = ($urandom % 16) == 0;
            bit c = ($urandom % 20) == 0;
            bit l = lock;
            logic [1:0] d = sel;
            if (($urandom % 40) == 0) l = ~lock;
            if (($urandom % 10) == 0) d = 2'($urandom % 4);
            drive(s, c, l, d);
            cycle((d != 2'(m_sel)) ? "R5" : "R4");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule